// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one channel of a general-purpose timer. It contains its own 16-bit up-counter with a programmable reload value. It compares that counter with a compare value and, under a 3-bit mode field, drives an active-high reference signal. Two pins are derived from the reference: a main output and a complementary output. Each has its own polarity bit and its own enable gating.

Software programs the channel through a small write port with three registers:

| Address | Register |
|---|---|
| 0 | Control word |
| 1 | Compare value |
| 2 | Reload value |

The compare value can be buffered in a shadow register, which is copied on every counter wrap. A rising edge on the trigger input restarts the counter. When fast mode is enabled and the channel is in a PWM mode, that same edge also acts as an immediate compare match, which gives a shorter response latency.

Top module: `oc_channel`

## Requirements
- R1: After reset the mode is frozen (000), the preload, fast, direction, enable and polarity fields are all 0, the compare value is 0, the reload value is 0xFFFF and the counter is 0. In this state `oc_ref`, `oc_main`, `oc_comp` and `match` are all 0.
- R2: The control word at address 0 has these fields: mode [2:0], preload [3], fast [4], direction [6:5], enable [7], main polarity [8], complementary polarity [9]. In the match modes, `oc_ref` changes on the clock edge that ends a cycle in which the counter is enabled and equals the compare value. Mode 001 sets it to 1, mode 010 clears it to 0, and mode 011 inverts it.
- R3: Mode 100 drives `oc_ref` to 0 and mode 101 drives it to 1. In both cases the output follows on the next edge, whatever the counter is doing.
- R4: In mode 000, `oc_ref` keeps its value while the counter runs and passes the compare value.
- R5: In mode 110, the PWM level is 1 while the counter is below the compare value and 0 otherwise. Mode 111 gives the inverse level. With reload value 9, one period of 10 cycles therefore holds min(C,10) high cycles in mode 110 and 10−min(C,10) in mode 111.
- R6: In modes 110 and 111, `oc_ref` takes the PWM level only on an edge where the comparison result differs from the previous cycle's result, or where the mode in the previous cycle was 000. Entering PWM from any other mode while the comparison is steady leaves `oc_ref` unchanged.
- R7: When preload is 0, a write to the compare register at address 1 takes effect from the next cycle.
- R8: When preload is 1, a write to address 1 loads only the shadow register. The shadow value is copied to the active compare value when the counter wraps. Until that wrap, the output behaves as it did with the old value.
- R9: With fast set and the mode 110 or 111, a rising trigger edge forces `oc_ref` to the level that follows a match: 0 for mode 110 and 1 for mode 111. The output changes on the 3rd clock edge after the trigger rises.
- R10: A rising trigger edge clears the counter on the 4th clock edge after the trigger rises. With fast clear, the earliest resulting `oc_ref` change is therefore on the 5th edge. Fast has no effect in modes 000 to 101.
- R11: When enable is 1, `oc_main` equals `oc_ref` XOR main polarity and `oc_comp` equals NOT `oc_ref` XOR complementary polarity. When enable is 0, each output sits at its polarity bit, which is its inactive level.
- R12: The direction field is written only when enable is currently 0; otherwise the write leaves it unchanged. While the direction field is not 00, `oc_ref` is held at 0.
- R13: While the counter enable is high, the counter counts up by 1 per cycle and wraps to 0 after reaching the reload value. `match` is high in every cycle in which the counter is enabled and equals the active compare value. With reload 9 there is one match per 10 cycles, and there are none while the counter enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 compare, 2 reload, 3 unused |
| wr_data | input | 16 | Write data |
| trig_in | input | 1 | Asynchronous trigger input; a rising edge restarts the counter |
| cnt_en | input | 1 | Counter enable |
| oc_ref | output | 1 | Active-high reference signal |
| oc_main | output | 1 | Polarity-adjusted main output |
| oc_comp | output | 1 | Polarity-adjusted complementary output |
| match | output | 1 | High while the counter equals the compare value and counts |

## Verification
The assertions assume the reload value is never written below the current count. This keeps the counter inside one reload period, so the wrap and preload checks stay meaningful. The stimulus sets the reload value to 9 once, while the counter is stopped at 0, and never changes it afterwards. The trigger is treated as a slow asynchronous level. The bench holds each trigger pulse for several cycles and waits before the next one, so every rising edge passes the synchronizer exactly once. All register writes are driven away from the clock edge.

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          trig_in,
  input  logic          cnt_en,
  output logic          oc_ref,
  output logic          oc_main,
  output logic          oc_comp,
  output logic          match
);

  logic [2:0]    mode_q, mode_prev;
  logic [1:0]    dir_q;
  logic          pre_q, fast_q, en_q, polm_q, polc_q;
  logic [CW-1:0] ccr_sh, ccr_act, arr_q, cnt_q;
  logic          ref_q, lt_prev;
  logic          s1, s2, s3, trig_d;

  wire ctrl_wr = wr_en && wr_addr == 2'd0;
  wire ccr_wr  = wr_en && wr_addr == 2'd1;
  wire arr_wr  = wr_en && wr_addr == 2'd2;
  wire ctrl_unused = &{1'b0, wr_data[CW-1:10]};

  wire hit       = cnt_en && cnt_q == ccr_act;
  wire upd       = cnt_en && cnt_q == arr_q;
  wire lt        = cnt_q < ccr_act;
  wire is_pwm    = mode_q[2:1] == 2'b11;
  wire pwm_lvl   = mode_q[0] ? !lt : lt;
  wire trig_edge = s2 && !s3;
  wire fast_fire = fast_q && is_pwm && trig_edge;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= 3'b000; pre_q <= 1'b0; fast_q <= 1'b0; dir_q <= 2'b00;
      en_q <= 1'b0; polm_q <= 1'b0; polc_q <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q <= wr_data[2:0];
      pre_q  <= wr_data[3];
      fast_q <= wr_data[4];
      if (!en_q) dir_q <= wr_data[6:5];
      en_q   <= wr_data[7];
      polm_q <= wr_data[8];
      polc_q <= wr_data[9];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ccr_sh <= '0; ccr_act <= '0; arr_q <= '1;
    end else begin
      if (arr_wr) arr_q <= wr_data;
      if (ccr_wr) ccr_sh <= wr_data;
      if (ccr_wr && !pre_q) ccr_act <= wr_data;
      else if (upd && pre_q) ccr_act <= ccr_sh;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0; trig_d <= 1'b0;
    end else begin
      s1 <= trig_in; s2 <= s1; s3 <= s2; trig_d <= trig_edge;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt_q <= '0;
    else if (trig_d) cnt_q <= '0;
    else if (upd)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lt_prev <= 1'b0; mode_prev <= 3'b000;
    end else begin
      lt_prev <= lt; mode_prev <= mode_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              ref_q <= 1'b0;
    else if (dir_q != 2'b00) ref_q <= 1'b0;
    else if (fast_fire)      ref_q <= mode_q[0];
    else
      case (mode_q)
        3'b000: ref_q <= ref_q;
        3'b001: if (hit) ref_q <= 1'b1;
        3'b010: if (hit) ref_q <= 1'b0;
        3'b011: if (hit) ref_q <= !ref_q;
        3'b100: ref_q <= 1'b0;
        3'b101: ref_q <= 1'b1;
        default:
          if (lt != lt_prev || mode_prev == 3'b000) ref_q <= pwm_lvl;
      endcase

  assign oc_ref  = ref_q;
  assign oc_main = en_q ? (ref_q ^ polm_q) : polm_q;
  assign oc_comp = en_q ? (!ref_q ^ polc_q) : polc_q;
  assign match   = hit;

  // R2
  set_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b001 && hit && dir_q == 2'b00) |=> oc_ref);
  // R3
  force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b100) |=> !oc_ref);
  // R3
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b101 && dir_q == 2'b00) |=> oc_ref);
  // R4
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b000 && dir_q == 2'b00) |=> $stable(oc_ref));
  // R6
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pwm && mode_prev != 3'b000 && lt == lt_prev && !trig_edge && dir_q == 2'b00)
      |=> $stable(oc_ref));
  // R7
  direct_ccr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_wr && !pre_q) |=> ccr_act == $past(wr_data));
  // R8
  shadow_ccr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_wr && pre_q && !upd) |=> $stable(ccr_act));
  // R9
  fast_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_edge && fast_q && is_pwm && dir_q == 2'b00) |=> oc_ref == $past(mode_q[0]));
  // R12
  dir_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q != 2'b00) |=> !oc_ref);
  // R12
  dir_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && en_q) |=> $stable(dir_q));
  // R13
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> cnt_q == '0);

endmodule

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, trig_in = 1'b0, cnt_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic oc_ref, oc_main, oc_comp, match;

  int total = 0, bad = 0;
  bit done = 1'b0;

  oc_channel dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_in(trig_in), .cnt_en(cnt_en), .oc_ref(oc_ref),
    .oc_main(oc_main), .oc_comp(oc_comp), .match(match));

  always #(CLK_P/2) clk = !clk;

  localparam logic [2:0] V_MODE [0:11] = '{3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b111,
                                           3'b111, 3'b111, 3'b100, 3'b101, 3'b111, 3'b110};
  localparam int V_CCR [0:11] = '{3, 0, 9, 10, 12, 3, 0, 10, 5, 5, 7, 7};
  localparam int V_EXP [0:11] = '{3, 0, 9, 10, 10, 7, 10, 0, 0, 10, 3, 7};

  function automatic logic [15:0] ctrl(input logic [2:0] m, input logic pre, input logic fst,
                                       input logic [1:0] dir, input logic en,
                                       input logic pm, input logic pc);
    return {6'b0, pc, pm, en, dir, fst, pre, m};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic trig_pulse();
    trig_in = 1'b1; cyc(4); trig_in = 1'b0; cyc(5);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (oc_ref) hi++;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    if (!done) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, tog;
    logic last;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 ref", oc_ref, 0);
    check("R1 main", oc_main, 0);
    check("R1 comp", oc_comp, 0);
    check("R1 match", match, 0);

    wr(2'd2, 16'd9);
    wr(2'd1, 16'd4);
    wr(2'd0, ctrl(3'b000, 0, 0, 2'b00, 1, 0, 0));
    // R13 match rate and wrap
    cnt_en = 1'b1;
    hi = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (match) hi++; end
    check("R13 matches per 30", hi, 3);
    cnt_en = 1'b0;
    hi = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (match) hi++; end
    check("R13 no match when stopped", hi, 0);
    cnt_en = 1'b1;

    // R5 R3 table walk
    for (int v = 0; v < 12; v++) begin
      wr(2'd0, ctrl(3'b000, 0, 0, 2'b00, 1, 0, 0));
      wr(2'd1, 16'(V_CCR[v]));
      wr(2'd0, ctrl(V_MODE[v], 0, 0, 2'b00, 1, 0, 0));
      cyc(20);
      count_high(10, hi);
      check($sformatf("R5 duty vec %0d", v), hi, V_EXP[v]);
    end

    // R2 set, clear, toggle on match
    wr(2'd1, 16'd4);
    wr(2'd0, ctrl(3'b100, 0, 0, 2'b00, 1, 0, 0)); cyc(2);
    wr(2'd0, ctrl(3'b001, 0, 0, 2'b00, 1, 0, 0)); cyc(12);
    check("R2 set on match", oc_ref, 1);
    wr(2'd0, ctrl(3'b010, 0, 0, 2'b00, 1, 0, 0)); cyc(12);
    check("R2 clear on match", oc_ref, 0);
    wr(2'd0, ctrl(3'b011, 0, 0, 2'b00, 1, 0, 0)); cyc(1);
    last = oc_ref; tog = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (oc_ref != last) tog++;
      last = oc_ref;
    end
    check("R2 toggles per 30", tog, 3);

    // R4 frozen holds
    wr(2'd0, ctrl(3'b101, 0, 0, 2'b00, 1, 0, 0)); cyc(2);
    wr(2'd0, ctrl(3'b000, 0, 0, 2'b00, 1, 0, 0));
    count_high(30, hi);
    check("R4 frozen high count", hi, 30);

    // R6 no change without comparison change
    wr(2'd0, ctrl(3'b100, 0, 0, 2'b00, 1, 0, 0)); cyc(2);
    wr(2'd1, 16'd12);
    wr(2'd0, ctrl(3'b110, 0, 0, 2'b00, 1, 0, 0));
    count_high(30, hi);
    check("R6 steady compare keeps ref", hi, 0);
    wr(2'd0, ctrl(3'b000, 0, 0, 2'b00, 1, 0, 0));
    wr(2'd0, ctrl(3'b110, 0, 0, 2'b00, 1, 0, 0)); cyc(2);
    check("R6 entry from frozen", oc_ref, 1);

    // R7 R8 preload, counter stopped at 0
    cnt_en = 1'b0;
    wr(2'd0, ctrl(3'b000, 0, 0, 2'b00, 1, 0, 0));
    trig_pulse();
    wr(2'd1, 16'd0);
    wr(2'd0, ctrl(3'b110, 0, 0, 2'b00, 1, 0, 0)); cyc(2);
    check("R7 pwm level ccr0", oc_ref, 0);
    wr(2'd1, 16'd5); cyc(2);
    check("R7 immediate compare", oc_ref, 1);
    wr(2'd0, ctrl(3'b110, 1, 0, 2'b00, 1, 0, 0));
    wr(2'd1, 16'd0); cyc(4);
    check("R8 shadow not yet active", oc_ref, 1);
    wr(2'd1, 16'd12);
    cnt_en = 1'b1; cyc(25);
    count_high(10, hi);
    check("R8 shadow applied at wrap", hi, 10);
    cnt_en = 1'b0;

    // R9 fast path, PWM2, counter stopped at 0
    wr(2'd0, ctrl(3'b000, 0, 0, 2'b00, 1, 0, 0));
    trig_pulse();
    wr(2'd1, 16'd8);
    wr(2'd0, ctrl(3'b111, 0, 1, 2'b00, 1, 0, 0)); cyc(3);
    check("R9 before trigger", oc_ref, 0);
    trig_in = 1'b1;
    cyc(2);
    check("R9 edge 2", oc_ref, 0);
    cyc(1);
    check("R9 edge 3", oc_ref, 1);
    trig_in = 1'b0; cyc(6);

    // R10 slow path, counter stopped at 5
    wr(2'd0, ctrl(3'b000, 0, 0, 2'b00, 1, 0, 0));
    trig_pulse();
    cnt_en = 1'b1; cyc(5); cnt_en = 1'b0;
    wr(2'd1, 16'd3);
    wr(2'd0, ctrl(3'b110, 0, 0, 2'b00, 1, 0, 0)); cyc(3);
    check("R10 before trigger", oc_ref, 0);
    trig_in = 1'b1;
    cyc(4);
    check("R10 edge 4", oc_ref, 0);
    cyc(1);
    check("R10 edge 5", oc_ref, 1);
    trig_in = 1'b0; cyc(6);
    wr(2'd0, ctrl(3'b100, 0, 0, 2'b00, 1, 0, 0)); cyc(2);
    trig_pulse();
    cnt_en = 1'b1; cyc(5); cnt_en = 1'b0;
    wr(2'd0, ctrl(3'b001, 0, 1, 2'b00, 1, 0, 0));
    trig_in = 1'b1;
    count_high(10, hi);
    check("R10 fast ignored in match mode", hi, 0);
    trig_in = 1'b0; cyc(6);

    // R11 polarity and enable gating
    wr(2'd0, ctrl(3'b101, 0, 0, 2'b00, 1, 0, 0)); cyc(2);
    check("R11 main pol0", oc_main, 1);
    check("R11 comp pol0", oc_comp, 0);
    wr(2'd0, ctrl(3'b101, 0, 0, 2'b00, 1, 1, 1)); cyc(2);
    check("R11 main pol1", oc_main, 0);
    check("R11 comp pol1", oc_comp, 1);
    wr(2'd0, ctrl(3'b101, 0, 0, 2'b00, 0, 1, 1)); cyc(2);
    check("R11 main disabled", oc_main, 1);
    check("R11 comp disabled", oc_comp, 1);

    // R12 direction lock and effect
    wr(2'd0, ctrl(3'b101, 0, 0, 2'b00, 1, 0, 0)); cyc(1);
    wr(2'd0, ctrl(3'b101, 0, 0, 2'b01, 1, 0, 0)); cyc(2);
    check("R12 dir write ignored while enabled", oc_ref, 1);
    wr(2'd0, ctrl(3'b101, 0, 0, 2'b00, 0, 0, 0));
    wr(2'd0, ctrl(3'b101, 0, 0, 2'b01, 0, 0, 0)); cyc(2);
    check("R12 input direction holds ref low", oc_ref, 0);
    wr(2'd0, ctrl(3'b101, 0, 0, 2'b00, 0, 0, 0)); cyc(2);
    check("R12 back to output", oc_ref, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule